// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers twenty interrupt request lines and drives one interrupt line to a single processor. Sources 0 to 15 are external pins and sources 16 to 19 are request lines from on-chip units. Each source has its own configuration word on a 32-bit register bus. The word holds an enable mask, a trigger kind (edge or level), a polarity, a 4-bit priority and an 8-bit vector. A read-only activity flag in the same word shows when the source is requesting or being serviced.

The processor takes an interrupt by reading the acknowledge register. The read returns the vector of the winning source and pushes that source onto a small in-service stack. Writing zero to the end-of-interrupt register pops the stack. A 4-bit task-priority register sets the level an interrupt must exceed to be delivered. A running handler also raises that level to its own priority, so only strictly more urgent sources can nest. A global register starts a one-cycle soft reset and stores a mode bit.

Byte addresses on the bus are 0x000 for global, 0x010 for task priority, 0x020 for acknowledge and 0x030 for end of interrupt. Source `i` sits at 0x200 + 16·i. Reads return data in the cycle after the read strobe.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset every source is masked with all other fields zero (its word reads 0x80000000), the task priority reads 0xF, the interrupt output is low and an acknowledge read returns 0xFF.
- R2: Writing the global register with bit 31 set starts a soft reset. Bit 31 reads back as 1 for one cycle and then clears itself. The soft reset returns task priority, source words, pending and in-service state to their reset values. Bit 29 stores the mode written and is not changed by the soft reset.
- R3: A source word reads back with mask in bit 31, activity in bit 30, polarity in bit 23, sense in bit 22, priority in bits 19:16 and vector in bits 7:0; all other bits read 0.
- R4: An acknowledge read returns the vector of the source that is driving the output in bits 7:0 and puts that source in service, so its activity bit stays 1. When nothing is deliverable the read returns 0xFF and changes no state.
- R5: The output is asserted only for a source whose priority is strictly greater than the task priority (bits 3:0 of its register).
- R6: A write of 0 to the end-of-interrupt register retires the most recently acknowledged source still in service. Earlier ones stay in service.
- R7: While a source's activity bit is 1, writes to its polarity, sense, priority and vector are ignored, and its mask bit remains writable.
- R8: With sense 0 (edge), polarity 1 latches a pending request on a rising input and polarity 0 on a falling one. The acknowledge clears the latch, and no new request appears until another edge.
- R9: With sense 1 (level), the request follows the input while it equals the polarity bit and vanishes when the input returns, with nothing latched.
- R10: A source is delivered only if its priority exceeds that of the most recently acknowledged source still in service, so equal priority waits and higher priority nests.
- R11: Among deliverable sources of equal priority, the lowest source index wins.
- R12: A masked source never drives the output, but its pending request is kept and is delivered once it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| regAddr | input | 12 | Register byte address |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after regRd |
| srcIn | input | 20 | Interrupt request inputs, source 0 in bit 0 |
| intOut | output | 1 | Interrupt request to the processor |

## Verification
On every cycle the assertions check four things. An acknowledge that delivers grows the in-service stack by one, and a zero end-of-interrupt write shrinks it by one. A source's priority and vector never change while it is active. The soft-reset flag lasts one cycle and leaves the task priority at 0xF with an empty stack. The bench scenarios are needed for behaviour that depends on the stimulus order: edge and level triggering of either polarity, ties broken by index, equal-priority blocking against nested preemption, a masked request surviving until unmask, and the readback encoding of every field.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int SRC_IDX_W = 5;
  localparam int PRIO_W    = 4;
  localparam int VEC_W     = 8;

  localparam logic [11:0] OFF_GLOBAL = 12'h000;
  localparam logic [11:0] OFF_TASK   = 12'h010;
  localparam logic [11:0] OFF_ACK    = 12'h020;
  localparam logic [11:0] OFF_EOI    = 12'h030;

  typedef enum logic [2:0] {RS_NONE, RS_ZERO, RS_GLOBAL, RS_TASK, RS_ACK, RS_SOURCE} rdSel_e;

  typedef struct packed {
    rdSel_e               rdSel;
    logic                 srcWr;
    logic                 taskWr;
    logic                 eoiWr;
    logic                 softRst;
    logic [SRC_IDX_W-1:0] idx;
  } ctlStrobes_t;

  typedef struct packed {
    logic              mask;
    logic              pol;
    logic              sense;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } srcCfg_t;

  localparam srcCfg_t CFG_RESET = '{1'b1, 1'b0, 1'b0, 4'h0, 8'h00};
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              glbRst,
  input  logic              glbMode,
  output ctlStrobes_t       ctl,
  output logic              busy,
  output logic              mode
);
  localparam int WIN_W = ADDR_W - 9;

  logic                 isGlb, isTask, isAck, isEoi, isSrc;
  logic [SRC_IDX_W-1:0] rawIdx;

  always_comb begin
    rawIdx = regAddr[8:4];
    isGlb  = regAddr == ADDR_W'(OFF_GLOBAL);
    isTask = regAddr == ADDR_W'(OFF_TASK);
    isAck  = regAddr == ADDR_W'(OFF_ACK);
    isEoi  = regAddr == ADDR_W'(OFF_EOI);
    isSrc  = (regAddr[ADDR_W-1:9] == WIN_W'(1)) && (regAddr[3:0] == 4'h0)
             && (rawIdx < SRC_IDX_W'(NUM_SRC));

    ctl         = '0;
    ctl.idx     = rawIdx;
    ctl.softRst = busy;
    ctl.srcWr   = regWr && isSrc;
    ctl.taskWr  = regWr && isTask;
    ctl.eoiWr   = regWr && isEoi;
    if (!regRd)      ctl.rdSel = RS_NONE;
    else if (isGlb)  ctl.rdSel = RS_GLOBAL;
    else if (isTask) ctl.rdSel = RS_TASK;
    else if (isAck)  ctl.rdSel = RS_ACK;
    else if (isSrc)  ctl.rdSel = RS_SOURCE;
    else             ctl.rdSel = RS_ZERO;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      mode <= 1'b0;
    end else begin
      if (busy) busy <= 1'b0;
      if (regWr && isGlb) begin
        mode <= glbMode;
        if (glbRst) busy <= 1'b1;
      end
    end
  end

  // R2: the reset flag lasts one cycle unless a new reset is requested
  p_busy_self_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(regWr && isGlb && glbRst)) |=> !busy);
endmodule

// File: rtl/vic_core.sv
module vic_core
  import vic_pkg::*;
#(
  parameter int NUM_SRC     = 20,
  parameter int STACK_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic [31:0]        wdata,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busy,
  input  logic               mode,
  output logic [31:0]        rdata,
  output logic               intOut
);
  localparam int SP_W = $clog2(STACK_DEPTH + 1);

  srcCfg_t              cfg [NUM_SRC];
  logic [NUM_SRC-1:0]   syncIn, prevIn, edgePend, inSvc;
  logic [NUM_SRC-1:0]   edgeHit, pend, active, cand;
  logic [PRIO_W-1:0]    taskPrio, bestPrio, topPrio;
  logic [SRC_IDX_W-1:0] bestIdx, topSrc;
  logic [SRC_IDX_W-1:0] stack [STACK_DEPTH];
  logic [SP_W-1:0]      stackCnt;
  logic                 bestVld, deliver, ackTake, popTake;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign edgeHit[i] = cfg[i].pol ? (syncIn[i] & ~prevIn[i]) : (~syncIn[i] & prevIn[i]);
    assign pend[i]    = cfg[i].sense ? (syncIn[i] == cfg[i].pol) : edgePend[i];
    assign active[i]  = pend[i] | inSvc[i];
    assign cand[i]    = pend[i] & ~cfg[i].mask & ~inSvc[i];

    // R7: an active source keeps its priority and vector
    p_cfg_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
      (active[i] && !ctl.softRst) |=> ($stable(cfg[i].prio) && $stable(cfg[i].vec)));
  end

  // strict compare keeps the lowest index on equal priority
  always_comb begin
    bestVld  = 1'b0;
    bestIdx  = '0;
    bestPrio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!bestVld || cfg[i].prio > bestPrio)) begin
        bestVld  = 1'b1;
        bestIdx  = SRC_IDX_W'(i);
        bestPrio = cfg[i].prio;
      end
    end
  end

  always_comb begin
    topSrc = '0;
    for (int k = 0; k < STACK_DEPTH; k++)
      if (SP_W'(k + 1) == stackCnt) topSrc = stack[k];
    topPrio = cfg[topSrc].prio;
  end

  assign deliver = bestVld && (bestPrio > taskPrio) && (stackCnt < SP_W'(STACK_DEPTH))
                   && ((stackCnt == '0) || (bestPrio > topPrio));
  assign intOut  = deliver;
  assign ackTake = (ctl.rdSel == RS_ACK) && deliver;
  assign popTake = ctl.eoiWr && (wdata == 32'h0) && (stackCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncIn <= '0;
      prevIn <= '0;
    end else begin
      syncIn <= srcIn;
      prevIn <= syncIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.softRst) begin
      for (int i = 0; i < NUM_SRC; i++) cfg[i] <= CFG_RESET;
      for (int k = 0; k < STACK_DEPTH; k++) stack[k] <= '0;
      edgePend <= '0;
      inSvc    <= '0;
      stackCnt <= '0;
      taskPrio <= '1;
    end else begin
      for (int i = 0; i < NUM_SRC; i++)
        if (edgeHit[i] && !cfg[i].sense) edgePend[i] <= 1'b1;
      if (ackTake) begin
        edgePend[bestIdx] <= 1'b0;
        inSvc[bestIdx]    <= 1'b1;
        for (int k = 0; k < STACK_DEPTH; k++)
          if (SP_W'(k) == stackCnt) stack[k] <= bestIdx;
        stackCnt <= stackCnt + SP_W'(1);
      end else if (popTake) begin
        inSvc[topSrc] <= 1'b0;
        stackCnt      <= stackCnt - SP_W'(1);
      end
      if (ctl.srcWr) begin
        cfg[ctl.idx].mask <= wdata[31];
        if (!active[ctl.idx]) begin
          cfg[ctl.idx].pol   <= wdata[23];
          cfg[ctl.idx].sense <= wdata[22];
          cfg[ctl.idx].prio  <= wdata[19:16];
          cfg[ctl.idx].vec   <= wdata[7:0];
        end
      end
      if (ctl.taskWr) taskPrio <= wdata[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else begin
      unique case (ctl.rdSel)
        RS_NONE:   rdata <= rdata;
        RS_ZERO:   rdata <= '0;
        RS_GLOBAL: rdata <= {busy, 1'b0, mode, 29'h0};
        RS_TASK:   rdata <= {28'h0, taskPrio};
        RS_ACK:    rdata <= deliver ? {24'h0, cfg[bestIdx].vec} : 32'h0000_00FF;
        RS_SOURCE: rdata <= {cfg[ctl.idx].mask, active[ctl.idx], 6'h0, cfg[ctl.idx].pol,
                             cfg[ctl.idx].sense, 2'h0, cfg[ctl.idx].prio, 8'h0,
                             cfg[ctl.idx].vec};
        default:   rdata <= '0;
      endcase
    end
  end

  // R4: a delivering acknowledge pushes one entry
  p_ack_push_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ackTake && !ctl.softRst) |=> stackCnt == $past(stackCnt) + SP_W'(1));
  // R6: a zero end-of-interrupt write pops one entry
  p_eoi_pop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.eoiWr && wdata == 32'h0 && stackCnt != '0 && !ctl.softRst)
      |=> stackCnt == $past(stackCnt) - SP_W'(1));
  // R2: soft reset restores the blocking threshold and empties service
  p_soft_reset_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.softRst |=> (taskPrio == 4'hF && stackCnt == '0 && inSvc == '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC     = 20,
  parameter int STACK_DEPTH = 4,
  parameter int ADDR_W      = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               intOut
);
  ctlStrobes_t ctl;
  logic        busy, mode;

  vic_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .glbRst(regWdata[31]), .glbMode(regWdata[29]),
    .ctl(ctl), .busy(busy), .mode(mode)
  );

  vic_core #(.NUM_SRC(NUM_SRC), .STACK_DEPTH(STACK_DEPTH)) u_core (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wdata(regWdata), .srcIn(srcIn),
    .busy(busy), .mode(mode), .rdata(regRdata), .intOut(intOut)
  );
endmodule

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [19:0] srcIn = '0;
  logic        intOut;

  int  checks = 0, errors = 0;
  bit  done = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  localparam logic [11:0] A_GLB = 12'h000, A_TASK = 12'h010, A_ACK = 12'h020, A_EOI = 12'h030;

  always #5 clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .srcIn(srcIn), .intOut(intOut)
  );

  // monitor: compares each read result against the scoreboard queue
  always @(posedge clk) rdSeen <= regRd;
  always @(negedge clk) begin
    if (rdSeen) begin
      logic [31:0] e;
      string t;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: got %h expected none", regRdata);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (regRdata !== e) begin
          errors++;
          $display("FAIL %s: read %h expected %h", t, regRdata, e);
        end
      end
    end
  end

  function automatic logic [11:0] srcAddr(input int i);
    return 12'h200 + 12'(i * 16);
  endfunction

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, input logic [31:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOut(input logic e, input string tag);
    checks++;
    if (intOut !== e) begin
      errors++;
      $display("FAIL %s: intOut %b expected %b", tag, intOut, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    checkOut(1'b0, "R1 output low");
    busRead(A_TASK, 32'h0000_000F, "R1 task prio");
    busRead(srcAddr(3), 32'h8000_0000, "R1 source masked");
    busRead(A_ACK, 32'h0000_00FF, "R1 empty ack");

    // R3 field layout, R13-style task readback under R5
    busWrite(srcAddr(2), 32'h0085_0042);
    busRead(srcAddr(2), 32'h0085_0042, "R3 readback");
    busWrite(A_TASK, 32'h0);
    busRead(A_TASK, 32'h0, "R5 task readback");

    // R8 rising edge, R7 lock, R12 mask keeps pending
    srcIn[2] = 1'b1; idle(3);
    checkOut(1'b1, "R8 rising edge delivers");
    busRead(srcAddr(2), 32'h4085_0042, "R3 activity bit");
    busWrite(srcAddr(2), 32'h0089_0055);
    busRead(srcAddr(2), 32'h4085_0042, "R7 locked fields");
    busWrite(srcAddr(2), 32'h8089_0055);
    busRead(srcAddr(2), 32'hC085_0042, "R7 mask writable");
    checkOut(1'b0, "R12 masked silent");
    busWrite(srcAddr(2), 32'h0085_0042);
    checkOut(1'b1, "R12 delivered after unmask");
    busRead(A_ACK, 32'h0000_0042, "R4 ack vector");
    checkOut(1'b0, "R4 source in service");
    busRead(srcAddr(2), 32'h4085_0042, "R4 in service active");
    srcIn[2] = 1'b0; idle(3);
    busWrite(A_EOI, 32'h0);
    busRead(srcAddr(2), 32'h0085_0042, "R6 retired");
    checkOut(1'b0, "R8 latch cleared by ack");

    // R5 strict threshold
    busWrite(A_TASK, 32'h5);
    srcIn[2] = 1'b1; idle(3);
    checkOut(1'b0, "R5 equal priority blocked");
    busWrite(A_TASK, 32'h4);
    checkOut(1'b1, "R5 lower threshold delivers");
    busRead(A_ACK, 32'h0000_0042, "R5 ack");
    busWrite(A_EOI, 32'h0);
    srcIn[2] = 1'b0; idle(3);
    busWrite(A_TASK, 32'h0);

    // R9 level active low
    srcIn[5] = 1'b1; idle(2);
    busWrite(srcAddr(5), 32'h0043_0010);
    checkOut(1'b0, "R9 inactive level");
    srcIn[5] = 1'b0; idle(2);
    checkOut(1'b1, "R9 low level requests");
    srcIn[5] = 1'b1; idle(2);
    checkOut(1'b0, "R9 no latch");
    srcIn[5] = 1'b0; idle(2);
    busRead(A_ACK, 32'h0000_0010, "R9 ack level");
    busWrite(A_EOI, 32'h0);
    checkOut(1'b1, "R9 level redelivers");
    srcIn[5] = 1'b1; idle(2);
    checkOut(1'b0, "R9 released");

    // R11 tie and R10 equal priority waits
    busWrite(srcAddr(7), 32'h0086_0007);
    busWrite(srcAddr(9), 32'h0086_0009);
    srcIn[9] = 1'b1; idle(1);
    srcIn[7] = 1'b1; idle(3);
    busRead(A_ACK, 32'h0000_0007, "R11 lower index wins");
    busRead(A_ACK, 32'h0000_00FF, "R10 equal priority waits");
    busWrite(A_EOI, 32'h0);
    busRead(A_ACK, 32'h0000_0009, "R11 second source");
    busWrite(A_EOI, 32'h0);
    srcIn[7] = 1'b0; srcIn[9] = 1'b0; idle(3);

    // R10 nesting, R6 pops only the top
    busWrite(srcAddr(11), 32'h008C_00B0);
    srcIn[2] = 1'b1; idle(3);
    busRead(A_ACK, 32'h0000_0042, "R10 outer ack");
    srcIn[11] = 1'b1; idle(3);
    checkOut(1'b1, "R10 higher nests");
    busRead(A_ACK, 32'h0000_00B0, "R10 inner ack");
    busWrite(A_EOI, 32'h0);
    busRead(srcAddr(11), 32'h008C_00B0, "R6 inner retired");
    busRead(srcAddr(2), 32'h4085_0042, "R6 outer still served");
    busWrite(A_EOI, 32'h0);
    busRead(srcAddr(2), 32'h0085_0042, "R6 outer retired");
    srcIn[2] = 1'b0; srcIn[11] = 1'b0; idle(3);

    // R8 falling edge
    srcIn[13] = 1'b1; idle(3);
    busWrite(srcAddr(13), 32'h0002_0033);
    checkOut(1'b0, "R8 no edge yet");
    srcIn[13] = 1'b0; idle(3);
    checkOut(1'b1, "R8 falling edge delivers");
    busRead(A_ACK, 32'h0000_0033, "R8 ack falling");
    busWrite(A_EOI, 32'h0);

    // R2 soft reset
    busWrite(A_GLB, 32'hA000_0000);
    busRead(A_GLB, 32'hA000_0000, "R2 busy visible");
    busRead(A_GLB, 32'h2000_0000, "R2 busy cleared, mode kept");
    busRead(A_TASK, 32'h0000_000F, "R2 task restored");
    busRead(srcAddr(2), 32'h8000_0000, "R2 source restored");
    checkOut(1'b0, "R2 output low");
    busWrite(A_GLB, 32'h0);
    busRead(A_GLB, 32'h0, "R2 mode cleared");

    idle(3);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard drain: got %0d expected 0", expQ.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule